// File: doc/BRIEF.md
# Store-Conditional Doubleword Unit

This unit performs a conditional 64-bit store built from two 32-bit register values. A small local reservation tracker is armed by a load-exclusive pulse that carries an address and a byte count. It is disarmed by an explicit clear input, and also by every store-conditional the unit accepts. When a store-conditional starts, the unit checks the tracker against the base address with a byte count of eight. It also checks that the base address is word aligned. Together these two checks decide one of four outcomes: write, fail, alignment abort, or bus abort after the write.

On the write path the unit first waits until the surrounding pipeline reports that all older stores have drained. This keeps release ordering. It then issues a single 64-bit request on a valid/ready memory port and waits for one response. The two words are arranged so that the first value always sits at the base address and the second at base+4. This means that big-endian and little-endian modes give opposite packings of the 64-bit data. The result is reported by a one-cycle `done` pulse, together with a 32-bit status word and a write-enable for the status destination. Two abort flags take the place of the write-enable when the operation faults.

Top module: `stxd_unit`

## Requirements
- R1: After a write whose response has no error, `done` pulses with `status_we`=1 and `status_word`=32'h0000_0000.
- R2: When the reservation check misses and the address is aligned, no memory request is issued, and `done` pulses with `status_we`=1 and `status_word`=32'h0000_0001.
- R3: The write request carries `mem_req_addr` equal to the base address. Its `mem_req_data` is {first, second} when `big_endian`=1 and {second, first} when `big_endian`=0, with bits [63:32] the upper word. Address and data stay stable while `mem_req_valid` is high and `mem_req_ready` is low.
- R4: If the reservation check hits and `base_addr[1:0]` is not 0, `done` pulses with `abort_align`=1 and `status_we`=0, and no request is issued.
- R5: If the reservation check misses and `base_addr[1:0]` is not 0, then `abort_align`=1 and `status_we`=0 when `fault_on_fail_misaligned`=1. When it is 0, the unit instead returns status 1 with `status_we`=1.
- R6: The reservation check hits only if the tracker is armed, its address equals `base_addr`, and its recorded byte count equals 8.
- R7: The tracker is disarmed by `mon_clear`, and by every accepted `start` whatever the outcome. When a clear and a load-exclusive arm occur in the same cycle, the clear wins.
- R8: `mem_req_valid` does not rise until `stores_drained` has been sampled high while the unit waits.
- R9: An error response to the write ends the operation with `abort_bus`=1 and `status_we`=0.
- R10: `start` is ignored while `busy` is high. It has no effect on the request, the outcome, or the number of `done` pulses.
- R11: After reset, `busy`, `done`, `status_we`, `mem_req_valid` and both abort flags are 0, and the tracker is disarmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fault_on_fail_misaligned | input | 1 | Raise the alignment abort on a misaligned access whose check misses |
| big_endian | input | 1 | Word packing mode for the 64-bit write |
| ldx_valid | input | 1 | Load-exclusive pulse that arms the tracker |
| ldx_addr | input | 32 | Address recorded by the load-exclusive |
| ldx_size | input | 4 | Byte count recorded by the load-exclusive |
| mon_clear | input | 1 | Disarm the tracker |
| start | input | 1 | Begin a store-conditional (accepted when not busy) |
| base_addr | input | 32 | Base address of the doubleword |
| word_first | input | 32 | Value destined for the base address |
| word_second | input | 32 | Value destined for base+4 |
| stores_drained | input | 1 | Older stores have completed |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| status_word | output | 32 | Status result, 0 on success, 1 on failure |
| status_we | output | 1 | Status destination write-enable |
| abort_align | output | 1 | Alignment abort, valid with done |
| abort_bus | output | 1 | Bus error abort, valid with done |
| mem_req_valid | output | 1 | Write request valid |
| mem_req_addr | output | 32 | Write request address |
| mem_req_data | output | 64 | Write request data |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_resp_valid | input | 1 | Write response valid |
| mem_resp_err | input | 1 | Write response reports an error |

## Verification
The store-conditional is driven with arming patterns that differ in one respect at a time: a matching tag and size, a wrong address, a wrong byte count, a tracker left unarmed, and one cleared explicitly or by an earlier store. Each pattern separates the hit path from a specific way of missing. Aligned and misaligned bases are crossed with hit and miss and with both settings of the fault configuration, which separates the alignment abort from a plain failure. Both packing modes use distinct word values, so a swapped order shows up in the request data. Slow drain, bus error and a second start while busy each show whether the write is held, whether the status write is suppressed, and whether a busy start is ignored.

// File: rtl/stxd_pkg.sv
// Shared definitions for the store-conditional doubleword unit.
// Assumes a 32-bit word and a 64-bit doubleword write.
package stxd_pkg;

    localparam int unsigned WORD_W   = 32;
    localparam int unsigned DWORD_W  = 2 * WORD_W;
    localparam int unsigned DW_BYTES = DWORD_W / 8;

    // Sequencer state of the store-conditional
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DRAIN = 2'd1,
        ST_REQ   = 2'd2,
        ST_RESP  = 2'd3
    } stxd_state_e;

    // Outcome decided when an operation is accepted
    typedef enum logic [1:0] {
        DEC_WRITE = 2'd0,
        DEC_FAIL  = 2'd1,
        DEC_ALIGN = 2'd2
    } stxd_decision_e;

endpackage

// File: rtl/stxd_monitor.sv
// Local reservation tracker.
// Holds an armed bit, a tagged address and a byte count. A load-exclusive
// arms it, and a clear (explicit or from an accepted store) disarms it.
// Clear has priority over arm. The probe reports a hit only when the tracker
// is armed, the tag matches and the recorded count equals the doubleword size.
module stxd_monitor #(
    parameter int unsigned ADDR_W  = 32,
    parameter int unsigned SIZE_W  = 4,
    parameter int unsigned DW_SIZE = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm_i,
    input  logic [ADDR_W-1:0] arm_addr_i,
    input  logic [SIZE_W-1:0] arm_size_i,
    input  logic              clear_i,
    input  logic [ADDR_W-1:0] probe_addr_i,
    output logic              hit_o
);

    localparam logic [SIZE_W-1:0] DW_SIZE_V = SIZE_W'(DW_SIZE);

    logic              armed_q;
    logic [ADDR_W-1:0] tag_q;
    logic [SIZE_W-1:0] size_q;

    // Arm state: clear wins over a simultaneous arm
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
        end else if (clear_i) begin
            armed_q <= 1'b0;
        end else if (arm_i) begin
            armed_q <= 1'b1;
        end
    end

    // Tag and size capture on an arm pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tag_q  <= '0;
            size_q <= '0;
        end else if (arm_i && !clear_i) begin
            tag_q  <= arm_addr_i;
            size_q <= arm_size_i;
        end
    end

    // Probe compare against the store address and doubleword size
    always_comb begin
        hit_o = armed_q && (tag_q == probe_addr_i) && (size_q == DW_SIZE_V);
    end

    AST_MON_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> !armed_q); // R7
    AST_MON_ARM_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (arm_i && !clear_i) |=> armed_q); // R6

endmodule

// File: rtl/stxd_pack.sv
// Doubleword assembly and alignment check.
// Places the first word at the base address and the second at base+4,
// which means the packing order swaps with the endianness mode.
// Flags an address whose low ALIGN_BITS bits are not zero.
module stxd_pack #(
    parameter int unsigned WORD_W     = 32,
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned ALIGN_BITS = 2
) (
    input  logic                  big_endian_i,
    input  logic [WORD_W-1:0]     first_i,
    input  logic [WORD_W-1:0]     second_i,
    input  logic [ADDR_W-1:0]     addr_i,
    output logic [2*WORD_W-1:0]   dword_o,
    output logic                  misaligned_o
);

    // Word packing by endianness
    always_comb begin
        if (big_endian_i) begin
            dword_o = {first_i, second_i};
        end else begin
            dword_o = {second_i, first_i};
        end
    end

    // Word alignment test on the low address bits
    generate
        if (ALIGN_BITS == 0) begin : g_no_align
            assign misaligned_o = 1'b0;
        end else begin : g_align
            assign misaligned_o = |addr_i[ALIGN_BITS-1:0];
        end
    endgenerate

endmodule

// File: rtl/stxd_ctrl.sv
// Store-conditional sequencer.
// Accepts start only when idle and decides the outcome from the reservation
// hit, the alignment test and the fault configuration. Write outcomes wait for
// the drain signal, hold a valid/ready request and then wait for one response.
// All completion outputs are registered and last one cycle with done.
module stxd_ctrl
    import stxd_pkg::*;
#(
    parameter int unsigned ADDR_W   = 32,
    parameter int unsigned DATA_W   = 64,
    parameter int unsigned STATUS_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic                hit_i,
    input  logic                misaligned_i,
    input  logic                fault_cfg_i,
    input  logic [ADDR_W-1:0]   addr_i,
    input  logic [DATA_W-1:0]   dword_i,
    input  logic                drained_i,
    input  logic                req_ready_i,
    input  logic                resp_valid_i,
    input  logic                resp_err_i,
    output logic                accept_o,
    output logic                busy_o,
    output logic                done_o,
    output logic [STATUS_W-1:0] status_o,
    output logic                status_we_o,
    output logic                abort_align_o,
    output logic                abort_bus_o,
    output logic                req_valid_o,
    output logic [ADDR_W-1:0]   req_addr_o,
    output logic [DATA_W-1:0]   req_data_o
);

    stxd_state_e     state_q, state_d;
    stxd_decision_e  decision;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;

    // Start is taken only from the idle state
    always_comb begin
        accept_o = start_i && (state_q == ST_IDLE);
    end

    // Outcome decision from reservation hit, alignment and fault setting
    always_comb begin
        if (misaligned_i && (hit_i || fault_cfg_i)) begin
            decision = DEC_ALIGN;
        end else if (hit_i && !misaligned_i) begin
            decision = DEC_WRITE;
        end else begin
            decision = DEC_FAIL;
        end
    end

    // Next-state logic of the sequencer
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (accept_o && decision == DEC_WRITE) state_d = ST_DRAIN;
            ST_DRAIN: if (drained_i) state_d = ST_REQ;
            ST_REQ:   if (req_ready_i) state_d = ST_RESP;
            ST_RESP:  if (resp_valid_i) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Capture address and data when an operation is accepted
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            data_q <= '0;
        end else if (accept_o) begin
            addr_q <= addr_i;
            data_q <= dword_i;
        end
    end

    // Registered completion pulse, status and abort flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_o        <= 1'b0;
            status_o      <= '0;
            status_we_o   <= 1'b0;
            abort_align_o <= 1'b0;
            abort_bus_o   <= 1'b0;
        end else begin
            done_o        <= 1'b0;
            status_we_o   <= 1'b0;
            abort_align_o <= 1'b0;
            abort_bus_o   <= 1'b0;
            if (accept_o && decision == DEC_FAIL) begin
                done_o      <= 1'b1;
                status_o    <= STATUS_W'(1);
                status_we_o <= 1'b1;
            end else if (accept_o && decision == DEC_ALIGN) begin
                done_o        <= 1'b1;
                abort_align_o <= 1'b1;
            end else if (state_q == ST_RESP && resp_valid_i) begin
                done_o <= 1'b1;
                if (resp_err_i) begin
                    abort_bus_o <= 1'b1;
                end else begin
                    status_o    <= '0;
                    status_we_o <= 1'b1;
                end
            end
        end
    end

    // Request and busy outputs from the sequencer state
    always_comb begin
        busy_o      = (state_q != ST_IDLE);
        req_valid_o = (state_q == ST_REQ);
        req_addr_o  = addr_q;
        req_data_o  = data_q;
    end

    AST_WE_EXCLUDES_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        status_we_o |-> !(abort_align_o || abort_bus_o)); // R9
    AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_o && !req_ready_i) |=> (req_valid_o && $stable(req_addr_o) && $stable(req_data_o))); // R3
    AST_REQ_AFTER_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_valid_o) |-> $past(drained_i)); // R8
    AST_ZERO_STATUS_AFTER_RESP: assert property (@(posedge clk) disable iff (!rst_n)
        (status_we_o && status_o == '0) |-> $past(resp_valid_i && !resp_err_i)); // R1
    AST_BUSY_BLOCKS_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !accept_o); // R10

endmodule

// File: rtl/stxd_unit.sv
// Store-conditional doubleword unit, top level.
// Connects the reservation tracker, the doubleword packer and the sequencer.
// The tracker is probed with the live base address at start and is disarmed
// by every accepted start and by the external clear.
module stxd_unit #(
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned WORD_W     = 32,
    parameter int unsigned SIZE_W     = 4,
    parameter int unsigned ALIGN_BITS = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  fault_on_fail_misaligned,
    input  logic                  big_endian,
    input  logic                  ldx_valid,
    input  logic [ADDR_W-1:0]     ldx_addr,
    input  logic [SIZE_W-1:0]     ldx_size,
    input  logic                  mon_clear,
    input  logic                  start,
    input  logic [ADDR_W-1:0]     base_addr,
    input  logic [WORD_W-1:0]     word_first,
    input  logic [WORD_W-1:0]     word_second,
    input  logic                  stores_drained,
    output logic                  busy,
    output logic                  done,
    output logic [WORD_W-1:0]     status_word,
    output logic                  status_we,
    output logic                  abort_align,
    output logic                  abort_bus,
    output logic                  mem_req_valid,
    output logic [ADDR_W-1:0]     mem_req_addr,
    output logic [2*WORD_W-1:0]   mem_req_data,
    input  logic                  mem_req_ready,
    input  logic                  mem_resp_valid,
    input  logic                  mem_resp_err
);

    localparam int unsigned DWORD_W = 2 * WORD_W;
    localparam int unsigned DW_SIZE = DWORD_W / 8;

    logic               hit;
    logic               misaligned;
    logic               accept;
    logic               clear_any;
    logic [DWORD_W-1:0] dword;

    // Tracker disarm on external clear or any accepted store
    always_comb begin
        clear_any = mon_clear || accept;
    end

    stxd_monitor #(
        .ADDR_W  (ADDR_W),
        .SIZE_W  (SIZE_W),
        .DW_SIZE (DW_SIZE)
    ) u_monitor (
        .clk          (clk),
        .rst_n        (rst_n),
        .arm_i        (ldx_valid),
        .arm_addr_i   (ldx_addr),
        .arm_size_i   (ldx_size),
        .clear_i      (clear_any),
        .probe_addr_i (base_addr),
        .hit_o        (hit)
    );

    stxd_pack #(
        .WORD_W     (WORD_W),
        .ADDR_W     (ADDR_W),
        .ALIGN_BITS (ALIGN_BITS)
    ) u_pack (
        .big_endian_i (big_endian),
        .first_i      (word_first),
        .second_i     (word_second),
        .addr_i       (base_addr),
        .dword_o      (dword),
        .misaligned_o (misaligned)
    );

    stxd_ctrl #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DWORD_W),
        .STATUS_W (WORD_W)
    ) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start),
        .hit_i         (hit),
        .misaligned_i  (misaligned),
        .fault_cfg_i   (fault_on_fail_misaligned),
        .addr_i        (base_addr),
        .dword_i       (dword),
        .drained_i     (stores_drained),
        .req_ready_i   (mem_req_ready),
        .resp_valid_i  (mem_resp_valid),
        .resp_err_i    (mem_resp_err),
        .accept_o      (accept),
        .busy_o        (busy),
        .done_o        (done),
        .status_o      (status_word),
        .status_we_o   (status_we),
        .abort_align_o (abort_align),
        .abort_bus_o   (abort_bus),
        .req_valid_o   (mem_req_valid),
        .req_addr_o    (mem_req_addr),
        .req_data_o    (mem_req_data)
    );

    AST_REQ_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> (mem_req_addr[ALIGN_BITS-1:0] == '0)); // R4
    AST_ABORT_ONLY_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (abort_align || abort_bus || status_we) |-> done); // R5

endmodule

// File: tb/stxd_unit_bench.sv
// Directed bench for the store-conditional doubleword unit.
module stxd_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fault_on_fail_misaligned = 1'b0;
    logic        big_endian = 1'b0;
    logic        ldx_valid = 1'b0;
    logic [31:0] ldx_addr = '0;
    logic [3:0]  ldx_size = '0;
    logic        mon_clear = 1'b0;
    logic        start = 1'b0;
    logic [31:0] base_addr = '0;
    logic [31:0] word_first = '0;
    logic [31:0] word_second = '0;
    logic        stores_drained = 1'b0;
    logic        busy, done, status_we, abort_align, abort_bus, mem_req_valid;
    logic [31:0] status_word, mem_req_addr;
    logic [63:0] mem_req_data;
    logic        mem_req_ready = 1'b0;
    logic        mem_resp_valid = 1'b0;
    logic        mem_resp_err = 1'b0;

    int nvec = 0;
    int nfail = 0;

    // Results of the last store-conditional
    logic        r_done, r_we, r_align, r_bus, r_req, r_drain_bad;
    logic [31:0] r_status, r_addr;
    logic [63:0] r_data;
    int          r_extra;

    always #4 clk = ~clk;

    stxd_unit u_stxd_unit (
        .clk (clk), .rst_n (rst_n),
        .fault_on_fail_misaligned (fault_on_fail_misaligned),
        .big_endian (big_endian),
        .ldx_valid (ldx_valid), .ldx_addr (ldx_addr), .ldx_size (ldx_size),
        .mon_clear (mon_clear),
        .start (start), .base_addr (base_addr),
        .word_first (word_first), .word_second (word_second),
        .stores_drained (stores_drained),
        .busy (busy), .done (done), .status_word (status_word),
        .status_we (status_we), .abort_align (abort_align), .abort_bus (abort_bus),
        .mem_req_valid (mem_req_valid), .mem_req_addr (mem_req_addr),
        .mem_req_data (mem_req_data), .mem_req_ready (mem_req_ready),
        .mem_resp_valid (mem_resp_valid), .mem_resp_err (mem_resp_err)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        nvec++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic arm(input logic [31:0] a, input logic [3:0] sz, input logic clr);
        @(negedge clk);
        ldx_valid = 1'b1; ldx_addr = a; ldx_size = sz; mon_clear = clr;
        @(negedge clk);
        ldx_valid = 1'b0; mon_clear = 1'b0;
    endtask

    task automatic clear_mon();
        @(negedge clk);
        mon_clear = 1'b1;
        @(negedge clk);
        mon_clear = 1'b0;
    endtask

    // Run one store-conditional, acting as drain source and memory
    task automatic run_stx(input logic [31:0] a, input logic [31:0] f, input logic [31:0] s,
                           input logic be, input logic cfg, input int drain_dly,
                           input logic err, input int inject_at);
        logic acc_pending = 1'b0;
        logic drained_hist = 1'b0;
        r_done = 0; r_we = 0; r_align = 0; r_bus = 0; r_req = 0; r_drain_bad = 0;
        r_status = '0; r_addr = '0; r_data = '0; r_extra = 0;
        @(negedge clk);
        start = 1'b1; base_addr = a; word_first = f; word_second = s;
        big_endian = be; fault_on_fail_misaligned = cfg;
        stores_drained = (drain_dly == 0);
        for (int cyc = 0; cyc < 60; cyc++) begin
            @(posedge clk); #1;
            if (stores_drained) drained_hist = 1'b1;
            if (mem_req_valid && !drained_hist) r_drain_bad = 1'b1;
            if (done) begin
                r_done = 1; r_we = status_we; r_align = abort_align;
                r_bus = abort_bus; r_status = status_word;
                break;
            end
            @(negedge clk);
            start = (cyc == inject_at);
            if (cyc == inject_at) begin
                base_addr = 32'h0000_2000; word_first = 32'h1111_1111; word_second = 32'h2222_2222;
            end
            stores_drained = (cyc + 1 >= drain_dly);
            mem_resp_valid = 1'b0; mem_resp_err = 1'b0;
            if (acc_pending) begin
                mem_resp_valid = 1'b1; mem_resp_err = err; acc_pending = 1'b0;
            end
            if (mem_req_valid) begin
                mem_req_ready = 1'b1; r_req = 1'b1;
                r_addr = mem_req_addr; r_data = mem_req_data; acc_pending = 1'b1;
            end else begin
                mem_req_ready = 1'b0;
            end
        end
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            start = 1'b0; mem_req_ready = 1'b0; mem_resp_valid = 1'b0; stores_drained = 1'b0;
            @(posedge clk); #1;
            if (done) r_extra++;
        end
    endtask

    task automatic t_reset();
        chk(!busy && !done && !status_we && !mem_req_valid && !abort_align && !abort_bus,
            "R11 reset outputs", {busy, done, status_we, mem_req_valid, abort_align, abort_bus}, 64'h0);
        run_stx(32'h100, 32'hA, 32'hB, 1'b0, 1'b0, 0, 1'b0, -1);
        chk(r_done && r_we && r_status == 32'h1 && !r_req, "R11 unarmed after reset", {32'h0, r_status}, 64'h1);
    endtask

    task automatic t_success(input logic be);
        logic [63:0] exp;
        exp = be ? 64'hAAAA_0001_BBBB_0002 : 64'hBBBB_0002_AAAA_0001;
        arm(32'h1000, 4'd8, 1'b0);
        run_stx(32'h1000, 32'hAAAA_0001, 32'hBBBB_0002, be, 1'b0, 0, 1'b0, -1);
        chk(r_req && r_data == exp, "R3 packing", r_data, exp);
        chk(r_addr == 32'h1000, "R3 address", {32'h0, r_addr}, 64'h1000);
        chk(r_done && r_we && r_status == 32'h0 && !r_align && !r_bus, "R1 success status",
            {32'h0, r_status}, 64'h0);
    endtask

    task automatic t_miss_tag();
        arm(32'h1000, 4'd8, 1'b0);
        run_stx(32'h1008, 32'h5, 32'h6, 1'b0, 1'b0, 0, 1'b0, -1);
        chk(!r_req && r_we && r_status == 32'h1, "R2 R6 tag miss", {31'h0, r_req, r_status}, 64'h1);
    endtask

    task automatic t_miss_size();
        arm(32'h1000, 4'd4, 1'b0);
        run_stx(32'h1000, 32'h5, 32'h6, 1'b0, 1'b0, 0, 1'b0, -1);
        chk(!r_req && r_we && r_status == 32'h1, "R6 size miss", {31'h0, r_req, r_status}, 64'h1);
    endtask

    task automatic t_clears();
        arm(32'h1000, 4'd8, 1'b0);
        run_stx(32'h1000, 32'h5, 32'h6, 1'b0, 1'b0, 0, 1'b0, -1);
        run_stx(32'h1000, 32'h5, 32'h6, 1'b0, 1'b0, 0, 1'b0, -1);
        chk(!r_req && r_status == 32'h1, "R7 cleared by store", {32'h0, r_status}, 64'h1);
        arm(32'h1000, 4'd8, 1'b0);
        clear_mon();
        run_stx(32'h1000, 32'h5, 32'h6, 1'b0, 1'b0, 0, 1'b0, -1);
        chk(!r_req && r_status == 32'h1, "R7 explicit clear", {32'h0, r_status}, 64'h1);
        arm(32'h1000, 4'd8, 1'b1);
        run_stx(32'h1000, 32'h5, 32'h6, 1'b0, 1'b0, 0, 1'b0, -1);
        chk(!r_req && r_status == 32'h1, "R7 clear beats arm", {32'h0, r_status}, 64'h1);
    endtask

    task automatic t_misaligned();
        arm(32'h1002, 4'd8, 1'b0);
        run_stx(32'h1002, 32'h5, 32'h6, 1'b0, 1'b0, 0, 1'b0, -1);
        chk(r_done && r_align && !r_we && !r_req, "R4 hit misaligned abort",
            {61'h0, r_align, r_we, r_req}, 64'h4);
        run_stx(32'h1002, 32'h5, 32'h6, 1'b0, 1'b1, 0, 1'b0, -1);
        chk(r_done && r_align && !r_we && !r_req, "R5 miss misaligned cfg1",
            {61'h0, r_align, r_we, r_req}, 64'h4);
        run_stx(32'h1001, 32'h5, 32'h6, 1'b0, 1'b0, 0, 1'b0, -1);
        chk(r_done && !r_align && r_we && r_status == 32'h1 && !r_req, "R5 miss misaligned cfg0",
            {61'h0, r_align, r_we, r_req}, 64'h2);
        run_stx(32'h1000, 32'h5, 32'h6, 1'b0, 1'b0, 0, 1'b0, -1);
        chk(!r_req && r_status == 32'h1, "R7 cleared by abort", {32'h0, r_status}, 64'h1);
    endtask

    task automatic t_drain();
        arm(32'h2000, 4'd8, 1'b0);
        run_stx(32'h2000, 32'h7, 32'h8, 1'b0, 1'b0, 6, 1'b0, -1);
        chk(r_req && !r_drain_bad, "R8 held until drained", {62'h0, r_req, r_drain_bad}, 64'h2);
        chk(r_we && r_status == 32'h0, "R8 completes after drain", {32'h0, r_status}, 64'h0);
    endtask

    task automatic t_bus_err();
        arm(32'h3000, 4'd8, 1'b0);
        run_stx(32'h3000, 32'h9, 32'hA, 1'b1, 1'b0, 0, 1'b1, -1);
        chk(r_done && r_bus && !r_we && !r_align, "R9 bus error abort", {62'h0, r_bus, r_we}, 64'h2);
    endtask

    task automatic t_busy_start();
        arm(32'h4000, 4'd8, 1'b0);
        run_stx(32'h4000, 32'hC, 32'hD, 1'b0, 1'b0, 5, 1'b0, 1);
        chk(r_addr == 32'h4000 && r_data == 64'h0000_000D_0000_000C, "R10 busy start ignored",
            r_data, 64'h0000_000D_0000_000C);
        chk(r_extra == 0 && r_status == 32'h0, "R10 single done", r_extra, 64'h0);
    endtask

    initial begin
        #(8 * 100000);
        nfail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_success(1'b0);
        t_success(1'b1);
        t_miss_tag();
        t_miss_size();
        t_clears();
        t_misaligned();
        t_drain();
        t_bus_err();
        t_busy_start();
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

endmodule